// File: doc/BRIEF.md
# Streaming FIR Filter Sequencer with a Single Multiply-Accumulate Unit

This block turns a stream of signed Q15 samples into a stream of filtered Q15 results. It has one multiplier and one 40-bit accumulator. Every accepted sample is written into a circular history buffer of `TAPS` entries. A sequencer then walks that history, newest entry first, against a coefficient table that it walks from index 0 upward. It adds one product per cycle, and the final product is added in the same step that rounds, saturates and registers the result. The operands for the next product are loaded in the same cycle as the current product is accumulated, so the engine spends exactly `TAPS` cycles per output.

The source presents a sample with `in_valid` for one cycle. The engine accepts it only while it is idle. A sample that arrives while a computation is running is dropped and raises a sticky overrun flag, because the real-time budget has been missed. Coefficients are written one at a time through an address/data/enable port.

The sequencer has three states:
- `ST_IDLE`: waiting for a sample. The ACCEPT transition (IDLE to LOOP) clears the accumulator, stores the sample, and loads the newest sample with coefficient 0.
- `ST_LOOP`: performs one product per cycle while fetching the next pair. STEP (LOOP to LOOP) repeats this, and EXIT (LOOP to LAST) is taken after `TAPS-1` products.
- `ST_LAST`: performs the closing product. WRITEBACK (LAST to IDLE) registers the result.

Top module: `fir_mac_seq`

## Requirements
- R1: After reset, `out_valid` and `overrun` are 0, and every history entry and every coefficient is 0. A first sample with no coefficient written therefore yields the result 0.
- R2: Each result equals the rounded and saturated value of sum over k = 0..TAPS-1 of c[k]*x[n-k]. Here x[n] is the sample just accepted, and history entries that were never written count as 0.
- R3: `out_valid` is high for exactly one cycle. It rises on the TAPS-th rising edge after the edge that accepted the sample, and it is low on every edge in between.
- R4: A sample with `in_valid` high on an edge where the engine is not idle is dropped and sets `overrun`. This includes the edge of the closing product. A dropped sample never enters the history, and the result in progress is unchanged.
- R5: Once `overrun` is set, it stays 1 until reset.
- R6: Rounding adds 2^14 to the 40-bit sum and then shifts it arithmetically right by 15, so a half LSB rounds toward +infinity.
- R7: A rounded value above 32767 is output as 32767 (0x7FFF), and one below -32768 is output as -32768 (0x8000).
- R8: The history is circular. After more than TAPS samples, the oldest one no longer contributes, and results stay correct over a long stream.
- R9: With `cw_en` high on an edge, `cw_data` is stored as coefficient c[`cw_addr`]. The coefficient at address k multiplies the sample that is k positions older than the newest one.
- R10: A sample presented while `out_valid` is high is accepted, so samples can be spaced TAPS+1 cycles apart without any loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_data | input | 16 | Signed Q15 sample |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | $clog2(TAPS) | Coefficient index |
| cw_data | input | 16 | Signed Q15 coefficient |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Signed Q15 result |
| overrun | output | 1 | Sticky flag for a dropped sample |

## Verification
Two events can fall in the same cycle: the arrival of a new sample and the closing product with its writeback. They can also coincide one cycle later, when a sample arrives while the result strobe is high. The bench drives a sample exactly on the LAST-state edge and checks three things: the result still matches the model, `overrun` rises, and the next result shows that the intruding sample never entered the history. It also drives a sample on the edge where `out_valid` is high and expects that sample to be accepted without an overrun. A sweep over impulse, ramp, rounding and saturation coefficient sets on a 4-tap build compares every result against an arithmetic model in the bench.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int DATA_W = 16;
    localparam int ACC_W  = 40;
    localparam int FRAC   = 15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_LAST = 2'd2
    } fir_state_e;

    localparam logic signed [ACC_W:0] RND_HALF = (ACC_W+1)'(2**(FRAC-1));
    localparam logic signed [ACC_W:0] SAT_HI   = (ACC_W+1)'(2**(DATA_W-1) - 1);
    localparam logic signed [ACC_W:0] SAT_LO   = -SAT_HI - (ACC_W+1)'(1);

    // Q30 sum to Q15: bias by half an LSB, arithmetic shift, clamp.
    function automatic logic [DATA_W-1:0] round_sat(input logic signed [ACC_W-1:0] sum);
        logic signed [ACC_W:0] biased;
        logic signed [ACC_W:0] scaled;
        biased = $signed({sum[ACC_W-1], sum}) + RND_HALF;
        scaled = biased >>> FRAC;
        if (scaled > SAT_HI)
            return SAT_HI[DATA_W-1:0];
        else if (scaled < SAT_LO)
            return SAT_LO[DATA_W-1:0];
        else
            return scaled[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/fir_hist_buf.sv
module fir_hist_buf #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_en && (wr_addr == PW'(i)))
                mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fir_coef_mem.sv
module fir_coef_mem #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_coef
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tbl[i] <= '0;
            else if (we && (waddr == PW'(i)))
                tbl[i] <= wdata;
        end
    end

    assign rdata = tbl[raddr];
endmodule

// File: rtl/fir_addr_gen.sv
module fir_addr_gen #(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] smp_ptr,
    output logic [PW-1:0] coef_ptr
);
    localparam logic [PW-1:0] TOP = PW'(DEPTH - 1);

    function automatic logic [PW-1:0] ring_dec(input logic [PW-1:0] p);
        return (p == '0) ? TOP : p - PW'(1);
    endfunction

    function automatic logic [PW-1:0] ring_inc(input logic [PW-1:0] p);
        return (p == TOP) ? '0 : p + PW'(1);
    endfunction

    // Sample pointer walks toward older entries, coefficient pointer walks up.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            smp_ptr  <= '0;
            coef_ptr <= '0;
        end else if (start) begin
            wr_ptr   <= ring_inc(wr_ptr);
            smp_ptr  <= ring_dec(wr_ptr);
            coef_ptr <= PW'(1);
        end else if (step) begin
            smp_ptr  <= ring_dec(smp_ptr);
            coef_ptr <= ring_inc(coef_ptr);
        end
    end
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
    parameter int DW = 16,
    parameter int AW = 40,
    localparam int PWID = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [AW-1:0] acc_next
);
    logic signed [AW-1:0]   acc_q;
    logic signed [PWID-1:0] prod;

    assign prod     = a * b;
    assign acc_next = acc_q + $signed({{(AW-PWID){prod[PWID-1]}}, prod});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clr)
            acc_q <= '0;
        else if (en)
            acc_q <= acc_next;
    end
endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq
    import fir_pkg::*;
#(
    parameter int TAPS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    input  logic                     cw_en,
    input  logic [$clog2(TAPS)-1:0]  cw_addr,
    input  logic [DATA_W-1:0]        cw_data,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic                     overrun
);
    localparam int PW = $clog2(TAPS);
    localparam logic [PW-1:0] EXIT_CNT = PW'(TAPS - 2);

    fir_state_e state_q, state_d;

    logic                     accept, step, finish;
    logic [PW-1:0]            wr_ptr, smp_ptr, coef_ptr, coef_raddr, step_cnt;
    logic [DATA_W-1:0]        hist_rd, coef_rd;
    logic signed [DATA_W-1:0] opa_q, opb_q;
    logic signed [ACC_W-1:0]  acc_next;

    assign accept = (state_q == ST_IDLE) && in_valid;
    assign step   = (state_q == ST_LOOP);
    assign finish = (state_q == ST_LAST);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions: ACCEPT, STEP, EXIT, WRITEBACK.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_LOOP;
            ST_LOOP: if (step_cnt == EXIT_CNT) state_d = ST_LAST;
            ST_LAST: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    fir_addr_gen #(.DEPTH(TAPS)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .step     (step),
        .wr_ptr   (wr_ptr),
        .smp_ptr  (smp_ptr),
        .coef_ptr (coef_ptr)
    );

    fir_hist_buf #(.DEPTH(TAPS), .DW(DATA_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_addr (wr_ptr),
        .wr_data (in_data),
        .rd_addr (smp_ptr),
        .rd_data (hist_rd)
    );

    assign coef_raddr = (state_q == ST_IDLE) ? '0 : coef_ptr;

    fir_coef_mem #(.DEPTH(TAPS), .DW(DATA_W)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cw_en),
        .waddr (cw_addr),
        .wdata (cw_data),
        .raddr (coef_raddr),
        .rdata (coef_rd)
    );

    // Operand fetch overlaps with the product being accumulated.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q    <= '0;
            opb_q    <= '0;
            step_cnt <= '0;
        end else if (accept) begin
            opa_q    <= $signed(in_data);
            opb_q    <= $signed(coef_rd);
            step_cnt <= '0;
        end else if (step) begin
            opa_q    <= $signed(hist_rd);
            opb_q    <= $signed(coef_rd);
            step_cnt <= step_cnt + PW'(1);
        end
    end

    fir_mac_unit #(.DW(DATA_W), .AW(ACC_W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .en       (step || finish),
        .a        (opa_q),
        .b        (opb_q),
        .acc_next (acc_next)
    );

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            overrun   <= 1'b0;
        end else begin
            out_valid <= finish;
            if (finish)
                out_data <= round_sat(acc_next);
            if (in_valid && (state_q != ST_IDLE))
                overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/fir_mac_chk.sv
module fir_mac_chk
    import fir_pkg::*;
#(
    parameter int TAPS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic       overrun,
    input fir_state_e st
);
    logic [7:0] since;

    // Edges since the last accepted sample, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since <= 8'hFF;
        else if (in_valid && st == ST_IDLE)
            since <= 8'd0;
        else if (since != 8'hFF)
            since <= since + 8'd1;
    end

    assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since == 8'(TAPS)));

    assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st != ST_IDLE) |=> overrun);

    assert_no_false_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!overrun && !(in_valid && st != ST_IDLE)) |=> !overrun);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind fir_mac_seq fir_mac_chk #(.TAPS(TAPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .overrun   (overrun),
    .st        (state_q)
);

// File: tb/sim_fir_mac_seq.sv
module sim_fir_mac_seq;
    localparam int TAPS = 4;
    localparam int AWID = $clog2(TAPS);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [15:0]     in_data = '0;
    logic            cw_en = 1'b0;
    logic [AWID-1:0] cw_addr = '0;
    logic [15:0]     cw_data = '0;
    logic            out_valid;
    logic [15:0]     out_data;
    logic            overrun;

    int n_chk = 0;
    int n_bad = 0;

    logic signed [15:0] cm [TAPS];
    logic signed [15:0] hm [TAPS];

    always #2.5 clk = ~clk;

    fir_mac_seq #(.TAPS(TAPS)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
        .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model();
        longint s = 0;
        for (int k = 0; k < TAPS; k++)
            s += longint'(cm[k]) * longint'(hm[k]);
        s = (s + 16384) >>> 15;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    task automatic clear_model();
        for (int k = 0; k < TAPS; k++) begin
            cm[k] = '0;
            hm[k] = '0;
        end
    endtask

    // Called at a negedge with the engine idle.
    task automatic put_coef(input int k, input logic signed [15:0] v);
        cw_en = 1'b1; cw_addr = AWID'(k); cw_data = v;
        @(negedge clk);
        cw_en = 1'b0;
        cm[k] = v;
    endtask

    // Called at a negedge with the engine idle; returns at the negedge with out_valid high.
    task automatic run_sample(input string req, input logic signed [15:0] v,
                              input bit junk_early, input bit junk_last);
        in_valid = 1'b1; in_data = v;
        @(negedge clk);
        chk("R3 low after accept", int'(out_valid), 0);
        in_valid = junk_early; in_data = 16'h5A5A;
        for (int k = TAPS - 1; k > 0; k--) hm[k] = hm[k-1];
        hm[0] = v;
        for (int c = 1; c < TAPS; c++) begin
            @(negedge clk);
            in_valid = (c == TAPS - 1) ? junk_last : 1'b0;
            in_data  = 16'h7E7E;
            if (c == TAPS - 1) chk("R3 low before result", int'(out_valid), 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R3 result strobe", int'(out_valid), 1);
        chk(req, int'($signed(out_data)), model());
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 overrun in reset", int'(overrun), 0);
        rst_n = 1'b1;
        clear_model();
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_model();
        do_reset();

        // R1: zero coefficients after reset.
        run_sample("R1 zero coefficients", 16'sd1000, 0, 0);

        // R2/R9/R8/R10: impulse at each tap, back-to-back stream.
        for (int j = 0; j < TAPS; j++) begin
            @(negedge clk);
            for (int k = 0; k < TAPS; k++) put_coef(k, (k == j) ? 16'sh4000 : 16'sh0000);
            for (int i = 0; i < 2 * TAPS; i++)
                run_sample("R9 tap position", 16'(i * 7919 + j * 12345), 0, 0);
        end

        // R2/R8: mixed coefficients over a long stream, R10 spacing.
        @(negedge clk);
        for (int k = 0; k < TAPS; k++) put_coef(k, 16'((k + 1) * 3000 * ((k % 2 == 0) ? 1 : -1)));
        for (int i = 0; i < 6 * TAPS; i++)
            run_sample("R8 circular stream R10", 16'(i * 4099 - 20000), 0, 0);
        chk("R10 no overrun on tight spacing", int'(overrun), 0);

        // R6: rounding with c0 = 1 LSB.
        @(negedge clk);
        for (int k = 0; k < TAPS; k++) put_coef(k, (k == 0) ? 16'sd1 : 16'sd0);
        run_sample("R6 half up", 16'sd16384, 0, 0);
        chk("R6 half up literal", int'($signed(out_data)), 1);
        run_sample("R6 below half", 16'sd16383, 0, 0);
        chk("R6 below half literal", int'($signed(out_data)), 0);
        run_sample("R6 negative half", -16'sd16384, 0, 0);
        chk("R6 negative half literal", int'($signed(out_data)), 0);
        run_sample("R6 negative past half", -16'sd16385, 0, 0);
        chk("R6 negative past half literal", int'($signed(out_data)), -1);

        // R7: saturation both ways.
        @(negedge clk);
        for (int k = 0; k < TAPS; k++) put_coef(k, 16'sh7FFF);
        for (int i = 0; i < TAPS; i++) run_sample("R7 positive", 16'sh7FFF, 0, 0);
        chk("R7 positive clamp literal", int'($signed(out_data)), 32767);
        for (int i = 0; i < TAPS; i++) run_sample("R7 negative", 16'sh8000, 0, 0);
        chk("R7 negative clamp literal", int'($signed(out_data)), -32768);

        // R4/R5: intrusions during the loop and on the writeback edge.
        @(negedge clk);
        for (int k = 0; k < TAPS; k++) put_coef(k, 16'(2000 + k * 1500));
        chk("R4 clean before intrusion", int'(overrun), 0);
        run_sample("R4 result with early intrusion", 16'sd5000, 1, 0);
        chk("R4 overrun set", int'(overrun), 1);
        run_sample("R4 dropped sample absent", -16'sd7000, 0, 0);
        run_sample("R4 result with writeback collision", 16'sd12000, 0, 1);
        run_sample("R4 collision sample absent", 16'sd3333, 0, 0);
        chk("R5 overrun sticky", int'(overrun), 1);
        repeat (5) @(negedge clk);
        chk("R5 overrun still set", int'(overrun), 1);

        // R1: reset clears flag, history and coefficients.
        do_reset();
        chk("R1 overrun cleared", int'(overrun), 0);
        put_coef(TAPS - 1, 16'sh4000);
        run_sample("R1 history cleared", 16'sd9000, 0, 0);
        chk("R1 history cleared literal", int'($signed(out_data)), 0);
        chk("R1 overrun after reset", int'(overrun), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule